// File: doc/BRIEF.md
# Digital Phase/Frequency Detector with Lock Indicator

This block compares a reference edge stream against a divided oscillator edge stream and reports which of the two is ahead. It has two active-low error outputs, one for each side, and they can be combined off-block into a loop error signal. The block runs in one fast sampling clock domain and takes both edge streams as synchronous inputs. Each rising edge of an input sets that side's internal flag. When both flags have been set for a programmable minimum number of cycles, both are cleared together. Because of this enforced coincident pulse, the detector has no dead zone near lock.

Four configuration inputs control the outputs. A polarity bit exchanges the roles of the two outputs. An output enable and a standby bit force both outputs to their high rest level. A lock-enable bit gates the lock indicator, which is the AND of the two error outputs. The lock indicator is low out of reset and stays low until it is enabled. In standby, a separate drive-enable output tells an external single-ended charge-pump driver to float.

Top module: `pfd_lock_top`

## Requirements
- R1: With polarity low and the oscillator edge arriving L cycles before the reference edge, `err_v_n` is low for L+MIN_PW sampled cycles and `err_r_n` is low for MIN_PW cycles.
- R2: With polarity low and the reference edge arriving L cycles before the oscillator edge, `err_r_n` is low for L+MIN_PW cycles and `err_v_n` is low for MIN_PW cycles.
- R3: Rising edges that are sampled in the same cycle give one low pulse of exactly MIN_PW cycles on both outputs at the same time. The two outputs are never both low for more than MIN_PW consecutive cycles.
- R4: With polarity high, the two outputs exchange roles: an oscillator edge that leads produces the long pulse on `err_r_n`.
- R5: While `out_en` is low, both error outputs stay high whatever the edge inputs do.
- R6: While `stby` is high, both error outputs stay high and `cp_drive_en` is low. With `stby` low, `cp_drive_en` is high, which is also its value out of reset.
- R7: While `lock_en` is high, `lock_out` equals `err_r_n AND err_v_n` in every cycle.
- R8: During reset `lock_out` is low. While `lock_en` is low, `lock_out` stays low.
- R9: A rising edge that is sampled in the cycle where both flags clear is not lost. It leaves its side's flag set, so that side's output stays low afterwards.
- R10: A sampled input edge first shows on its error output one clock after the edge that samples it. Reset sets both error outputs high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference edge stream |
| vco_in | input | 1 | Divided oscillator edge stream |
| pol_swap | input | 1 | 1 exchanges the roles of the two error outputs |
| out_en | input | 1 | 1 enables the error outputs |
| stby | input | 1 | 1 selects standby (outputs at rest, drive floated) |
| lock_en | input | 1 | 1 enables the lock indicator |
| err_r_n | output | 1 | Active-low error output, reference side (polarity low) |
| err_v_n | output | 1 | Active-low error output, oscillator side (polarity low) |
| lock_out | output | 1 | Lock indicator, AND of both error outputs when enabled |
| cp_drive_en | output | 1 | Three-state enable for the external charge-pump drive |

## Verification
The bench counts pulse widths for leads in both directions. A design with the wrong coincidence width, or one that clears the flags too early, would give lengths other than L+MIN_PW and MIN_PW. Edges in the same cycle must give equal pulses of exactly MIN_PW, and a dead-zone design would give no pulse at all. One test places a new reference edge in the clear cycle: a design that clears without capturing that edge would release `err_r_n`. The disable, standby, polarity and lock-gating tests catch outputs that leak pulses while forced to rest, roles that fail to swap, and a lock output that reports lock from reset or while disabled.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  // Pair of detector flags, one per compared stream
  typedef struct packed {
    logic r;
    logic v;
  } pfd_pair_t;

  // Width needed to count 0..n
  function automatic int unsigned cnt_width(input int unsigned n);
    int unsigned w;
    w = 1;
    while ((1 << w) <= n) w++;
    return w;
  endfunction
endpackage

// File: rtl/pfd_edge_det.sv
module pfd_edge_det #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) prev_q[g] <= 1'b0;
      else     prev_q[g] <= din[g];
    end
    assign rise[g] = din[g] & ~prev_q[g];
  end
endmodule

// File: rtl/pfd_core.sv
module pfd_core
  import pfd_pkg::*;
#(
  parameter int unsigned MIN_PW = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      rise_r,
  input  logic      rise_v,
  output pfd_pair_t flags
);
  localparam int unsigned CW = cnt_width(MIN_PW);
  localparam logic [CW-1:0] LAST = CW'(MIN_PW - 1);

  pfd_pair_t   ff_q;
  logic [CW-1:0] cnt_q;
  logic        both;
  logic        clr;

  assign both = ff_q.r & ff_q.v;
  assign clr  = both && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      ff_q  <= '0;
      cnt_q <= '0;
    end else if (clr) begin
      // joint clear; an edge seen this cycle survives the clear
      ff_q.r <= rise_r;
      ff_q.v <= rise_v;
      cnt_q  <= '0;
    end else begin
      ff_q.r <= ff_q.r | rise_r;
      ff_q.v <= ff_q.v | rise_v;
      cnt_q  <= both ? cnt_q + CW'(1) : '0;
    end
  end

  assign flags = ff_q;
endmodule

// File: rtl/pfd_out_stage.sv
module pfd_out_stage
  import pfd_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  pfd_pair_t flags,
  input  logic      pol_swap,
  input  logic      out_en,
  input  logic      stby,
  input  logic      lock_en,
  output logic      err_r_n,
  output logic      err_v_n,
  output logic      lock_out,
  output logic      cp_drive_en
);
  logic sel_r, sel_v, drive, nxt_r_n, nxt_v_n;

  always_comb begin
    sel_r   = pol_swap ? flags.v : flags.r;
    sel_v   = pol_swap ? flags.r : flags.v;
    drive   = out_en & ~stby;
    nxt_r_n = ~(drive & sel_r);
    nxt_v_n = ~(drive & sel_v);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_r_n     <= 1'b1;
      err_v_n     <= 1'b1;
      lock_out    <= 1'b0;
      cp_drive_en <= 1'b1;
    end else begin
      err_r_n     <= nxt_r_n;
      err_v_n     <= nxt_v_n;
      lock_out    <= lock_en & nxt_r_n & nxt_v_n;
      cp_drive_en <= ~stby;
    end
  end
endmodule

// File: rtl/pfd_lock_top.sv
module pfd_lock_top
  import pfd_pkg::*;
#(
  parameter int unsigned MIN_PW = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_in,
  input  logic vco_in,
  input  logic pol_swap,
  input  logic out_en,
  input  logic stby,
  input  logic lock_en,
  output logic err_r_n,
  output logic err_v_n,
  output logic lock_out,
  output logic cp_drive_en
);
  localparam int unsigned NCH = 2;

  logic [NCH-1:0] edge_in, edge_rise;
  pfd_pair_t      flags;

  assign edge_in = {vco_in, ref_in};

  pfd_edge_det #(.N(NCH)) edge_i (
    .clk  (clk),
    .rst  (rst),
    .din  (edge_in),
    .rise (edge_rise)
  );

  pfd_core #(.MIN_PW(MIN_PW)) core_i (
    .clk    (clk),
    .rst    (rst),
    .rise_r (edge_rise[0]),
    .rise_v (edge_rise[1]),
    .flags  (flags)
  );

  pfd_out_stage out_i (
    .clk         (clk),
    .rst         (rst),
    .flags       (flags),
    .pol_swap    (pol_swap),
    .out_en      (out_en),
    .stby        (stby),
    .lock_en     (lock_en),
    .err_r_n     (err_r_n),
    .err_v_n     (err_v_n),
    .lock_out    (lock_out),
    .cp_drive_en (cp_drive_en)
  );
endmodule

// File: rtl/pfd_lock_chk.sv
module pfd_lock_chk #(
  parameter int unsigned MIN_PW = 2
) (
  input logic clk,
  input logic rst,
  input logic out_en,
  input logic stby,
  input logic lock_en,
  input logic err_r_n,
  input logic err_v_n,
  input logic lock_out,
  input logic cp_drive_en
);
  logic [7:0] both_low_q;

  always_ff @(posedge clk) begin
    if (rst) both_low_q <= '0;
    else if (!err_r_n && !err_v_n) begin
      if (both_low_q != 8'hFF) both_low_q <= both_low_q + 8'd1;
    end else both_low_q <= '0;
  end

  // R3: coincident low pulse never longer than MIN_PW
  a_r3_min_pw: assert property (@(posedge clk) disable iff (rst)
    (both_low_q <= 8'(MIN_PW)));

  // R5: disabled outputs rest high
  a_r5_disable_rest: assert property (@(posedge clk) disable iff (rst)
    (!out_en |=> (err_r_n && err_v_n)));

  // R6: standby floats the drive and rests the outputs
  a_r6_stby_float: assert property (@(posedge clk) disable iff (rst)
    (stby |=> (!cp_drive_en && err_r_n && err_v_n)));

  // R7: lock high only when both outputs are high
  a_r7_lock_and: assert property (@(posedge clk) disable iff (rst)
    (lock_out |-> (err_r_n && err_v_n)));

  // R8: lock disabled forces low
  a_r8_lock_off: assert property (@(posedge clk) disable iff (rst)
    (!lock_en |=> !lock_out));
endmodule

bind pfd_lock_top pfd_lock_chk #(.MIN_PW(MIN_PW)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .out_en      (out_en),
  .stby        (stby),
  .lock_en     (lock_en),
  .err_r_n     (err_r_n),
  .err_v_n     (err_v_n),
  .lock_out    (lock_out),
  .cp_drive_en (cp_drive_en)
);

// File: tb/pfd_lock_top_tb_top.sv
module pfd_lock_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MIN_PW     = 2;
  localparam int NSTEP      = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_in = 1'b0, vco_in = 1'b0;
  logic pol_swap = 1'b0, out_en = 1'b1, stby = 1'b0, lock_en = 1'b1;
  logic err_r_n, err_v_n, lock_out, cp_drive_en;

  int checks = 0;
  int failures = 0;
  int low_r, low_v, low_both, low_lock;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfd_lock_top #(.MIN_PW(MIN_PW)) dut_i (
    .clk(clk), .rst(rst), .ref_in(ref_in), .vco_in(vco_in),
    .pol_swap(pol_swap), .out_en(out_en), .stby(stby), .lock_en(lock_en),
    .err_r_n(err_r_n), .err_v_n(err_v_n), .lock_out(lock_out),
    .cp_drive_en(cp_drive_en)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; ref_in = 1'b0; vco_in = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // sample previous edge's outputs, then drive inputs for the next edge
  task automatic step(input logic r, input logic v);
    @(negedge clk);
    if (!err_r_n) low_r++;
    if (!err_v_n) low_v++;
    if (!err_r_n && !err_v_n) low_both++;
    if (!lock_out) low_lock++;
    ref_in = r;
    vco_in = v;
  endtask

  // one-cycle pulses: oscillator at step dv, reference at step dr
  task automatic run_pair(input int dv, input int dr);
    low_r = 0; low_v = 0; low_both = 0; low_lock = 0;
    for (int k = 0; k < NSTEP; k++) step(k == dr, k == dv);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R10 reset err_r_n", int'(err_r_n), 1);
    check("R10 reset err_v_n", int'(err_v_n), 1);
    check("R8 reset lock_out", int'(lock_out), 0);
    check("R6 reset cp_drive_en", int'(cp_drive_en), 1);
    rst = 1'b0;
  endtask

  task automatic t_v_leads();
    do_reset();
    run_pair(0, 3);
    check("R1 v long pulse", low_v, 3 + MIN_PW);
    check("R1 r short pulse", low_r, MIN_PW);
    check("R7 lock low count", low_lock, 3 + MIN_PW);
  endtask

  task automatic t_r_leads();
    do_reset();
    run_pair(4, 0);
    check("R2 r long pulse", low_r, 4 + MIN_PW);
    check("R2 v short pulse", low_v, MIN_PW);
  endtask

  task automatic t_coincident();
    do_reset();
    run_pair(1, 1);
    check("R3 r pulse", low_r, MIN_PW);
    check("R3 v pulse", low_v, MIN_PW);
    check("R3 both low", low_both, MIN_PW);
  endtask

  task automatic t_polarity();
    do_reset();
    pol_swap = 1'b1;
    run_pair(0, 3);
    check("R4 r long pulse", low_r, 3 + MIN_PW);
    check("R4 v short pulse", low_v, MIN_PW);
    pol_swap = 1'b0;
  endtask

  task automatic t_disable();
    do_reset();
    out_en = 1'b0;
    run_pair(0, 3);
    check("R5 r rest", low_r, 0);
    check("R5 v rest", low_v, 0);
    check("R7 lock high while rest", low_lock, 0);
    out_en = 1'b1;
  endtask

  task automatic t_standby();
    do_reset();
    stby = 1'b1;
    run_pair(2, 0);
    check("R6 r rest", low_r, 0);
    check("R6 v rest", low_v, 0);
    check("R6 drive floated", int'(cp_drive_en), 0);
    stby = 1'b0;
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    check("R6 drive restored", int'(cp_drive_en), 1);
  endtask

  task automatic t_lock_off();
    do_reset();
    lock_en = 1'b0;
    run_pair(0, 0);
    check("R8 lock held low", low_lock, NSTEP);
    lock_en = 1'b1;
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    check("R7 lock high when enabled", int'(lock_out), 1);
  endtask

  task automatic t_clear_capture();
    do_reset();
    low_r = 0; low_v = 0; low_both = 0; low_lock = 0;
    step(1'b1, 1'b0); // ref edge e0
    step(1'b0, 1'b1); // vco edge e1
    step(1'b0, 1'b0);
    step(1'b1, 1'b0); // new ref edge in the clear cycle e3
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    check("R9 r still low", int'(err_r_n), 0);
    check("R9 v released", int'(err_v_n), 1);
  endtask

  task automatic t_latency();
    do_reset();
    step(1'b0, 1'b1);           // edge e0 samples vco rise
    @(posedge clk); #1;         // just after e0
    check("R10 no output yet", int'(err_v_n), 1);
    @(posedge clk); #1;         // just after e1
    check("R10 output after one clock", int'(err_v_n), 0);
    vco_in = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_v_leads();
    t_r_leads();
    t_coincident();
    t_polarity();
    t_disable();
    t_standby();
    t_lock_off();
    t_clear_capture();
    t_latency();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule